// File: doc/BRIEF.md
# GF(2^8) P/Q Parity Accumulator

This block builds dual-parity syndromes over a stream of source words, as used for double-failure protection in a disk array. Each cycle it may accept one 64-bit word made of eight byte lanes, together with an 8-bit Galois-field coefficient and per-source control flags. The P accumulator is the plain XOR of every source that has P enabled. The Q accumulator XORs in each source after every byte lane has been multiplied in GF(2^8) by that source's coefficient.

The field reduction polynomial comes from an input rather than a fixed constant. Software drives the low eight coefficients of a monic degree-8 polynomial. A first flag starts a fresh operation and a last flag closes it. P and Q each raise their own valid flag once the operation is closed.

Top module: `gf_pq_accum`

## Requirements
- R1: After reset, p_o and q_o are all zeros and p_valid_o and q_valid_o are low.
- R2: p_o after the closing beat equals the XOR of src_data_i over every beat of the operation with src_p_en_i high.
- R3: q_o after the closing beat equals the XOR, over every beat with src_q_en_i high, of that beat's data with each byte lane multiplied in GF(2^8) by src_mul_i. The reduction polynomial is x^8 plus the sum of poly_i[k]·x^k for k = 0..7.
- R4: poly_i is sampled on each beat, so the same data and coefficient give different Q results under different polynomials. For example, 0x80·0x02 yields 0x1D with poly_i = 0x1D and 0x1B with poly_i = 0x1B, and 0x53·0xCA yields 0x01 with poly_i = 0x1B.
- R5: Byte lane k of q_o (bits 8k+7..8k) depends only on byte lane k of the source data; there is no carry between lanes.
- R6: A coefficient of 0x01 adds the data to Q unchanged, and a coefficient of 0x00 adds zero.
- R7: A beat with src_first_i high loads each accumulator instead of XORing into it. An accumulator whose enable is low on that beat is cleared to zero.
- R8: On a beat without src_first_i, an accumulator whose enable is low keeps its value.
- R9: p_valid_o and q_valid_o rise on the clock edge that accepts a beat with src_last_i high. Each rises only if its own enable was high on at least one beat of the operation. Each stays high until the next accepted beat, and is low after any accepted beat without src_last_i.
- R10: While src_valid_i is low, no output changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| poly_i | input | 8 | Coefficients of x^7..x^0 of the reduction polynomial |
| src_valid_i | input | 1 | Source beat present this cycle |
| src_data_i | input | 64 | Source word, eight byte lanes |
| src_mul_i | input | 8 | GF(2^8) coefficient for the Q term |
| src_p_en_i | input | 1 | Include this source in P |
| src_q_en_i | input | 1 | Include this source in Q |
| src_first_i | input | 1 | First source of an operation |
| src_last_i | input | 1 | Last source of an operation |
| p_o | output | 64 | P accumulator |
| p_valid_o | output | 1 | P result complete |
| q_o | output | 64 | Q accumulator |
| q_valid_o | output | 1 | Q result complete |

## Verification
The hardest case to reach is the valid rule for an accumulator that no source enabled. The bench gets there by closing operations where one side has no enabled source at all, while the other side is enabled only on a middle beat. It then checks that only the touched side raises its flag. Two other cases need care. The first-beat clear is exercised with the accumulator holding stale non-zero data from an earlier operation. Polynomial sensitivity is shown by repeating the same beat under two polynomials and comparing against known field products.

// File: rtl/gfpq_pkg.sv
package gfpq_pkg;
  localparam int unsigned SYM_W = 8;
  typedef logic [SYM_W-1:0] sym_t;
endpackage

// File: rtl/gf_sym_mul.sv
// One GF(2^8) product: shift-and-add with reduction by x^8 + poly.
module gf_sym_mul
  import gfpq_pkg::*;
(
  input  sym_t a_i,
  input  sym_t b_i,
  input  sym_t poly_i,
  output sym_t p_o
);
  sym_t pw [SYM_W];
  sym_t ps [SYM_W+1];

  assign pw[0] = a_i;
  assign ps[0] = '0;

  for (genvar i = 0; i < SYM_W; i++) begin : g_step
    assign ps[i+1] = b_i[i] ? (ps[i] ^ pw[i]) : ps[i];
    if (i < SYM_W - 1) begin : g_xt
      assign pw[i+1] = {pw[i][SYM_W-2:0], 1'b0} ^ (pw[i][SYM_W-1] ? poly_i : sym_t'(0));
    end
  end

  assign p_o = ps[SYM_W];
endmodule

// File: rtl/gf_word_mul.sv
module gf_word_mul
  import gfpq_pkg::*;
#(
  parameter int unsigned LANES = 8,
  localparam int unsigned DW = LANES * SYM_W
) (
  input  logic [DW-1:0] data_i,
  input  sym_t          mul_i,
  input  sym_t          poly_i,
  output logic [DW-1:0] prod_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    gf_sym_mul u_mul (
      .a_i    (data_i[l*SYM_W +: SYM_W]),
      .b_i    (mul_i),
      .poly_i (poly_i),
      .p_o    (prod_o[l*SYM_W +: SYM_W])
    );
  end
endmodule

// File: rtl/pq_acc.sv
// One parity accumulator with its completion flag.
module pq_acc #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         beat_i,
  input  logic         first_i,
  input  logic         last_i,
  input  logic         en_i,
  input  logic [W-1:0] term_i,
  output logic [W-1:0] acc_o,
  output logic         valid_o
);
  logic         touched_q, touched_d;
  logic [W-1:0] acc_d;

  always_comb begin
    if (first_i) begin
      acc_d     = en_i ? term_i : '0;
      touched_d = en_i;
    end else begin
      acc_d     = en_i ? (acc_o ^ term_i) : acc_o;
      touched_d = touched_q | en_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o     <= '0;
      touched_q <= 1'b0;
      valid_o   <= 1'b0;
    end else if (beat_i) begin
      acc_o     <= acc_d;
      touched_q <= touched_d;
      valid_o   <= last_i & touched_d;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beat_i |=> $stable(acc_o) && $stable(valid_o)); // R10
  AST_DISABLED_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i && !first_i && !en_i |=> $stable(acc_o)); // R8
  AST_FIRST_OFF_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i && first_i && !en_i |=> acc_o == '0); // R7
  AST_VALID_MIDOP_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_i && !last_i |=> !valid_o); // R9
endmodule

// File: rtl/gf_pq_accum.sv
module gf_pq_accum
  import gfpq_pkg::*;
#(
  parameter int unsigned LANES = 8,
  localparam int unsigned DW = LANES * SYM_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    poly_i,
  input  logic          src_valid_i,
  input  logic [DW-1:0] src_data_i,
  input  logic [7:0]    src_mul_i,
  input  logic          src_p_en_i,
  input  logic          src_q_en_i,
  input  logic          src_first_i,
  input  logic          src_last_i,
  output logic [DW-1:0] p_o,
  output logic          p_valid_o,
  output logic [DW-1:0] q_o,
  output logic          q_valid_o
);
  logic [DW-1:0] q_term;

  gf_word_mul #(.LANES(LANES)) u_wmul (
    .data_i (src_data_i),
    .mul_i  (src_mul_i),
    .poly_i (poly_i),
    .prod_o (q_term)
  );

  pq_acc #(.W(DW)) u_p (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .beat_i  (src_valid_i),
    .first_i (src_first_i),
    .last_i  (src_last_i),
    .en_i    (src_p_en_i),
    .term_i  (src_data_i),
    .acc_o   (p_o),
    .valid_o (p_valid_o)
  );

  pq_acc #(.W(DW)) u_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .beat_i  (src_valid_i),
    .first_i (src_first_i),
    .last_i  (src_last_i),
    .en_i    (src_q_en_i),
    .term_i  (q_term),
    .acc_o   (q_o),
    .valid_o (q_valid_o)
  );

  AST_MUL_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_valid_i && src_mul_i == 8'h01 |-> q_term == src_data_i); // R6
  AST_MUL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_valid_i && src_mul_i == 8'h00 |-> q_term == '0); // R6
endmodule

// File: tb/gf_pq_accum_tb_top.sv
`timescale 1ns/1ps
module gf_pq_accum_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  poly = 8'h1D;
  logic        vld = 1'b0;
  logic [63:0] dat = '0;
  logic [7:0]  mul = '0;
  logic        pe = 1'b0, qe = 1'b0, fst = 1'b0, lst = 1'b0;
  logic [63:0] p_o, q_o;
  logic        p_valid_o, q_valid_o;

  int nchk = 0, nfail = 0;
  bit done = 0;

  logic [63:0] mp = '0, mq = '0;
  logic        mpt = 0, mqt = 0, mpv = 0, mqv = 0;

  always #2 clk = ~clk;

  gf_pq_accum dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .poly_i(poly), .src_valid_i(vld),
    .src_data_i(dat), .src_mul_i(mul), .src_p_en_i(pe), .src_q_en_i(qe),
    .src_first_i(fst), .src_last_i(lst), .p_o(p_o), .p_valid_o(p_valid_o),
    .q_o(q_o), .q_valid_o(q_valid_o)
  );

  function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b, logic [7:0] pl);
    logic [7:0] r = 0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= a;
      a = a[7] ? ((a << 1) ^ pl) : (a << 1);
    end
    return r;
  endfunction

  function automatic logic [63:0] gword(logic [63:0] d, logic [7:0] m, logic [7:0] pl);
    logic [63:0] r;
    for (int l = 0; l < 8; l++) r[l*8 +: 8] = gmul(d[l*8 +: 8], m, pl);
    return r;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_model(string tag);
    chk({tag, " p"}, p_o, mp);
    chk({tag, " q"}, q_o, mq);
    chk({tag, " pv"}, {63'd0, p_valid_o}, {63'd0, mpv});
    chk({tag, " qv"}, {63'd0, q_valid_o}, {63'd0, mqv});
  endtask

  task automatic beat(logic [63:0] d, logic [7:0] m, logic p_en, logic q_en, logic f, logic l);
    logic [63:0] t;
    @(negedge clk);
    vld = 1; dat = d; mul = m; pe = p_en; qe = q_en; fst = f; lst = l;
    @(posedge clk); #1;
    t = gword(d, m, poly);
    if (f) begin mp = p_en ? d : '0; mpt = p_en; mq = q_en ? t : '0; mqt = q_en; end
    else begin
      if (p_en) mp ^= d;
      if (q_en) mq ^= t;
      mpt |= p_en; mqt |= q_en;
    end
    mpv = l & mpt; mqv = l & mqt;
    @(negedge clk);
    vld = 0;
  endtask

  task automatic t_reset;
    chk("R1 p", p_o, '0);
    chk("R1 q", q_o, '0);
    chk("R1 valids", {62'd0, p_valid_o, q_valid_o}, '0);
  endtask

  task automatic t_p_stream;
    poly = 8'h1D;
    beat(64'h0123_4567_89AB_CDEF, 8'h03, 1, 0, 1, 0);
    beat(64'hFFFF_0000_FFFF_0000, 8'h05, 1, 0, 0, 0);
    beat(64'h1111_2222_3333_4444, 8'h07, 1, 0, 0, 1);
    chk("R2 p", p_o, 64'h0123_4567_89AB_CDEF ^ 64'hFFFF_0000_FFFF_0000 ^ 64'h1111_2222_3333_4444);
    chk_model("R2/R9 p-only");
  endtask

  task automatic t_known;
    poly = 8'h1D;
    beat(64'h80, 8'h02, 0, 1, 1, 1);
    chk("R4 0x80*2 poly1D", q_o, 64'h1D);
    poly = 8'h1B;
    beat(64'h80, 8'h02, 0, 1, 1, 1);
    chk("R4 0x80*2 poly1B", q_o, 64'h1B);
    beat(64'h53, 8'hCA, 0, 1, 1, 1);
    chk("R4 0x53*CA poly1B", q_o, 64'h01);
  endtask

  task automatic t_mixed;
    poly = 8'h1D;
    beat(64'hDEAD_BEEF_CAFE_F00D, 8'h02, 1, 1, 1, 0);
    beat(64'h0F1E_2D3C_4B5A_6978, 8'h8E, 1, 1, 0, 0);
    beat(64'hA5A5_5A5A_C3C3_3C3C, 8'hF1, 1, 1, 0, 0);
    beat(64'h7766_5544_3322_1100, 8'h47, 1, 1, 0, 1);
    chk_model("R3 mixed");
    poly = 8'h71;
    beat(64'h0102_0408_1020_4080, 8'hB3, 1, 1, 1, 0);
    beat(64'hFEDC_BA98_7654_3210, 8'h6D, 0, 1, 0, 1);
    chk_model("R3/R4 poly71");
  endtask

  task automatic t_lanes;
    poly = 8'h1D;
    beat(64'h0000_0000_C700_0000, 8'h57, 0, 1, 1, 1);
    chk("R5 lane3 only", q_o, {32'd0, gmul(8'hC7, 8'h57, 8'h1D), 24'd0});
    beat(64'hFF00_0000_0000_0001, 8'h39, 0, 1, 1, 1);
    chk("R5 lanes 0 and 7", q_o, {gmul(8'hFF, 8'h39, 8'h1D), 48'd0, gmul(8'h01, 8'h39, 8'h1D)});
  endtask

  task automatic t_mul_edges;
    beat(64'h9876_5432_10FE_DCBA, 8'h01, 0, 1, 1, 1);
    chk("R6 mul one", q_o, 64'h9876_5432_10FE_DCBA);
    beat(64'h1357_9BDF_2468_ACE0, 8'h11, 0, 1, 1, 0);
    beat(64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 0, 1, 0, 1);
    chk("R6 mul zero", q_o, gword(64'h1357_9BDF_2468_ACE0, 8'h11, poly));
  endtask

  task automatic t_first_reload;
    beat(64'h5555_6666_7777_8888, 8'h09, 1, 1, 1, 1);
    beat(64'h0000_1111_0000_2222, 8'h0A, 0, 1, 1, 1);
    chk("R7 p cleared on first", p_o, '0);
    chk("R7 q loaded", q_o, gword(64'h0000_1111_0000_2222, 8'h0A, poly));
    chk_model("R7/R9");
  endtask

  task automatic t_disable_keep;
    beat(64'h0A0B_0C0D_0E0F_1011, 8'h33, 1, 1, 1, 0);
    beat(64'hFFFF_FFFF_0000_0000, 8'h44, 0, 0, 0, 0);
    chk("R8 p kept", p_o, 64'h0A0B_0C0D_0E0F_1011);
    chk("R8 q kept", q_o, gword(64'h0A0B_0C0D_0E0F_1011, 8'h33, poly));
    beat(64'h0000_0000_FFFF_FFFF, 8'h55, 1, 0, 0, 1);
    chk_model("R8 partial enables");
  endtask

  task automatic t_idle;
    logic [63:0] sp, sq;
    beat(64'h2468_1357_2468_1357, 8'h21, 1, 1, 1, 1);
    sp = p_o; sq = q_o;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      dat = {8{8'(i * 37 + 5)}}; mul = 8'(i + 3); pe = 1; qe = 1; fst = i[0]; lst = 1;
      poly = 8'(8'h2B + i);
    end
    @(posedge clk); #1;
    chk("R10 p idle", p_o, sp);
    chk("R10 q idle", q_o, sq);
    chk("R10 valids idle", {62'd0, p_valid_o, q_valid_o}, 64'd3);
    poly = 8'h1D;
  endtask

  task automatic t_valid;
    beat(64'h1, 8'h02, 0, 0, 1, 0);
    chk_model("R9 mid op low");
    beat(64'h2, 8'h03, 0, 1, 0, 0);
    beat(64'h4, 8'h04, 0, 0, 0, 1);
    chk("R9 p untouched low", {63'd0, p_valid_o}, 64'd0);
    chk("R9 q touched high", {63'd0, q_valid_o}, 64'd1);
    chk_model("R9 end");
    beat(64'h8, 8'h05, 1, 1, 1, 0);
    chk("R9 cleared by next beat", {62'd0, p_valid_o, q_valid_o}, 64'd0);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk) rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_p_stream();
    t_known();
    t_mixed();
    t_lanes();
    t_mul_edges();
    t_first_reload();
    t_disable_keep();
    t_idle();
    t_valid();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule